// File: doc/BRIEF.md
# Chip-Select Match Resolver

This block sits beside an external bus master. It decides how each outgoing transfer is carried on the external bus. Software programs ten address windows through a small write port: eight chip-select windows and two DRAM block windows. Each window has a base address, a don't-care mask, an enable bit, attribute permissions, and per-window cycle settings.

When the master issues a transfer start, every window is compared in parallel against the address and the access attributes. The block counts how many chip-select windows and how many DRAM windows hit. From the two counts it picks one of five outcomes:

- plain external access;
- a single chip-select with its own settings;
- several chip-selects with a forced safe cycle;
- a single DRAM block;
- an illegal overlap that is flagged as an error.

The result is captured in the start cycle and held for the rest of the bus cycle. The DRAM controller and the bus cycle timing lie outside this block.

Top module: `csd_resolver`

## Requirements
- R1: While reset is active, and afterwards until the first start, the outputs read as follows: no chip-select, no DRAM select, width code 00, burst inhibit high, internal termination low, wait count 0, error low, kind 0.
- R2: A window hits only when its enable bit (control bit 0) is set and the address equals the base on every bit whose mask bit is 0. Mask bits set to 1 are ignored in the comparison.
- R3: A window hits only if it allows the access attributes. For reads it needs control bit 1 set, and for writes control bit 2. For supervisor accesses it needs control bit 3 set, and for user accesses control bit 4.
- R4: When nothing hits, the kind is 0 (external). There is no select, the width code is 00 (32-bit), burst inhibit is 1, internal termination is 0 and the wait count is 0.
- R5: When exactly one chip-select hits and no DRAM window hits, only that chip-select bit is set and the kind is 1. The outputs come from that window's control fields:
  - width code from bits 6:5 (00 = 32-bit, 01 = 8-bit, 10 = 16-bit; 11 reads as 00);
  - internal termination from bit 7;
  - wait count from bits 11:8;
  - burst inhibit as the inverse of bit 12.
- R6: When two or more chip-selects hit and no DRAM window hits, every hitting chip-select bit is set and the kind is 2. The cycle is forced to width 00, burst inhibit 1, internal termination 0 and wait 0.
- R7: When exactly one DRAM window hits and no chip-select hits, its bit in the DRAM select is set and the kind is 3. The width code is 00 and internal termination is 1. The wait count comes from bits 11:8 of that window, and burst inhibit is the inverse of its bit 12.
- R8: When both DRAM windows hit, or a DRAM window and any chip-select hit, the error flag is 1 and the kind is 4. No selects are driven, and the cycle falls back to width 00, burst inhibit 1, internal termination 0 and wait 0.
- R9: The outputs change only on the clock edge that samples start high. They then hold through idle cycles and through configuration writes.
- R10: A configuration write is made with the write enable high. Index 0–7 selects a chip-select window and index 8–9 a DRAM window. Field 0 writes the base, field 1 the mask and field 2 the control word. Field 3 and indices 10 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Window index |
| cfg_fld | input | 2 | Field select (0 base, 1 mask, 2 control) |
| cfg_data | input | 32 | Write data |
| start | input | 1 | Transfer start; captures the decode |
| addr | input | 32 | Transfer address |
| is_write | input | 1 | 1 = write, 0 = read |
| is_super | input | 1 | 1 = supervisor, 0 = user |
| cs_sel | output | 8 | Chip-select vector, active high |
| dram_sel | output | 2 | DRAM block select, active high |
| port_width | output | 2 | Width code |
| burst_inh | output | 1 | Burst inhibit |
| int_ack_en | output | 1 | Internal termination enable |
| wait_cnt | output | 4 | Wait-state count |
| undef_err | output | 1 | Illegal overlap flag |
| acc_kind | output | 3 | Outcome code 0–4 |

## Verification
A window that was stored wrongly, or a wrong hit count, shows up on the first access aimed at that window. It appears one clock after the start edge, as a wrong select vector, a wrong kind or wrong cycle fields. A capture register that follows the inputs instead of holding would show as outputs moving during idle cycles or configuration writes. The stimulus therefore covers every count combination, the attribute-denied and mask-boundary addresses, ignored writes, and the hold behaviour.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int N_CS   = 8;
    localparam int N_DR   = 2;
    localparam int N_WIN  = N_CS + N_DR;
    localparam int IDX_W  = $clog2(N_WIN);
    localparam int WAIT_W = 4;
    localparam int KIND_W = 3;

    // control word bit positions
    localparam int C_VALID = 0;
    localparam int C_RD    = 1;
    localparam int C_WR    = 2;
    localparam int C_SUP   = 3;
    localparam int C_USR   = 4;
    localparam int C_PW_LO = 5;
    localparam int C_IACK  = 7;
    localparam int C_WT_LO = 8;
    localparam int C_BURST = 12;

    localparam logic [1:0] PW_32 = 2'b00;
    localparam logic [1:0] PW_8  = 2'b01;
    localparam logic [1:0] PW_16 = 2'b10;

    localparam logic [KIND_W-1:0] K_EXT   = 3'd0;
    localparam logic [KIND_W-1:0] K_CS    = 3'd1;
    localparam logic [KIND_W-1:0] K_MULTI = 3'd2;
    localparam logic [KIND_W-1:0] K_DRAM  = 3'd3;
    localparam logic [KIND_W-1:0] K_UNDEF = 3'd4;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic              valid;
        logic              rd;
        logic              wr;
        logic              sup;
        logic              usr;
        logic [1:0]        pw;
        logic              iack;
        logic [WAIT_W-1:0] wait_n;
        logic              burst;
    } win_t;

    typedef struct packed {
        logic [N_CS-1:0]   cs;
        logic [N_DR-1:0]   dr;
        logic [1:0]        pw;
        logic              binh;
        logic              iack;
        logic [WAIT_W-1:0] wait_n;
        logic              undef;
        logic [KIND_W-1:0] kind;
    } dec_t;

    localparam dec_t DEC_IDLE = '{cs: '0, dr: '0, pw: PW_32, binh: 1'b1,
                                  iack: 1'b0, wait_n: '0, undef: 1'b0, kind: K_EXT};
endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
    import csd_pkg::*;
#(
    parameter int NW = N_WIN,
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [1:0]    fld_i,
    input  logic [DW-1:0] data_i,
    output win_t          win_o [NW]
);
    logic [DW-1:0] base_d [NW];
    logic [DW-1:0] base_q [NW];
    logic [DW-1:0] mask_d [NW];
    logic [DW-1:0] mask_q [NW];
    logic [DW-1:0] ctrl_d [NW];
    logic [DW-1:0] ctrl_q [NW];

    always_comb begin
        base_d = base_q;
        mask_d = mask_q;
        ctrl_d = ctrl_q;
        if (we_i && (idx_i < IW'(NW))) begin
            case (fld_i)
                2'd0:    base_d[idx_i] = data_i;
                2'd1:    mask_d[idx_i] = data_i;
                2'd2:    ctrl_d[idx_i] = data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
                ctrl_q[i] <= '0;
            end
        end else begin
            base_q <= base_d;
            mask_q <= mask_d;
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_unpack
        always_comb begin
            win_o[g].base   = base_q[g];
            win_o[g].mask   = mask_q[g];
            win_o[g].valid  = ctrl_q[g][C_VALID];
            win_o[g].rd     = ctrl_q[g][C_RD];
            win_o[g].wr     = ctrl_q[g][C_WR];
            win_o[g].sup    = ctrl_q[g][C_SUP];
            win_o[g].usr    = ctrl_q[g][C_USR];
            win_o[g].pw     = ctrl_q[g][C_PW_LO +: 2];
            win_o[g].iack   = ctrl_q[g][C_IACK];
            win_o[g].wait_n = ctrl_q[g][C_WT_LO +: WAIT_W];
            win_o[g].burst  = ctrl_q[g][C_BURST];
        end
    end
endmodule

// File: rtl/csd_window_match.sv
module csd_window_match
    import csd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  win_t          win_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          sup_i,
    output logic          hit_o
);
    logic addr_ok;
    logic dir_ok;
    logic mode_ok;

    always_comb begin
        addr_ok = (((addr_i ^ win_i.base) & ~win_i.mask) == '0);
        dir_ok  = wr_i  ? win_i.wr  : win_i.rd;
        mode_ok = sup_i ? win_i.sup : win_i.usr;
        hit_o   = win_i.valid && addr_ok && dir_ok && mode_ok;
    end
endmodule

// File: rtl/csd_resolve.sv
module csd_resolve
    import csd_pkg::*;
#(
    parameter int NC = N_CS,
    parameter int ND = N_DR
) (
    input  logic [NC-1:0] cs_hit_i,
    input  logic [ND-1:0] dr_hit_i,
    input  win_t          win_i [NC+ND],
    output dec_t          dec_o
);
    localparam int CW = $clog2(NC + 1) + 1;
    localparam int DCW = $clog2(ND + 1) + 1;

    logic [CW-1:0]     n_cs;
    logic [DCW-1:0]    n_dr;
    logic [1:0]        cs_pw;
    logic              cs_iack;
    logic [WAIT_W-1:0] cs_wait;
    logic              cs_burst;
    logic [WAIT_W-1:0] dr_wait;
    logic              dr_burst;

    always_comb begin
        n_cs = '0;
        for (int i = 0; i < NC; i++) n_cs = n_cs + CW'(cs_hit_i[i]);
        n_dr = '0;
        for (int j = 0; j < ND; j++) n_dr = n_dr + DCW'(dr_hit_i[j]);

        cs_pw = '0; cs_iack = 1'b0; cs_wait = '0; cs_burst = 1'b0;
        for (int i = 0; i < NC; i++) begin
            if (cs_hit_i[i]) begin
                cs_pw    = cs_pw    | win_i[i].pw;
                cs_iack  = cs_iack  | win_i[i].iack;
                cs_wait  = cs_wait  | win_i[i].wait_n;
                cs_burst = cs_burst | win_i[i].burst;
            end
        end
        dr_wait = '0; dr_burst = 1'b0;
        for (int j = 0; j < ND; j++) begin
            if (dr_hit_i[j]) begin
                dr_wait  = dr_wait  | win_i[NC + j].wait_n;
                dr_burst = dr_burst | win_i[NC + j].burst;
            end
        end

        dec_o = DEC_IDLE;
        if (n_dr != '0 && (n_cs != '0 || n_dr > DCW'(1))) begin
            dec_o.undef = 1'b1;
            dec_o.kind  = K_UNDEF;
        end else if (n_dr == DCW'(1)) begin
            dec_o.dr     = dr_hit_i;
            dec_o.iack   = 1'b1;
            dec_o.wait_n = dr_wait;
            dec_o.binh   = ~dr_burst;
            dec_o.kind   = K_DRAM;
        end else if (n_cs == CW'(1)) begin
            dec_o.cs     = cs_hit_i;
            dec_o.pw     = (cs_pw == 2'b11) ? PW_32 : cs_pw;
            dec_o.iack   = cs_iack;
            dec_o.wait_n = cs_wait;
            dec_o.binh   = ~cs_burst;
            dec_o.kind   = K_CS;
        end else if (n_cs > CW'(1)) begin
            dec_o.cs   = cs_hit_i;
            dec_o.kind = K_MULTI;
        end
    end
endmodule

// File: rtl/csd_resolver.sv
module csd_resolver
    import csd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [1:0]         cfg_fld,
    input  logic [DATA_W-1:0]  cfg_data,
    input  logic               start,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_write,
    input  logic               is_super,
    output logic [N_CS-1:0]    cs_sel,
    output logic [N_DR-1:0]    dram_sel,
    output logic [1:0]         port_width,
    output logic               burst_inh,
    output logic               int_ack_en,
    output logic [WAIT_W-1:0]  wait_cnt,
    output logic               undef_err,
    output logic [KIND_W-1:0]  acc_kind
);
    win_t            win [N_WIN];
    logic [N_WIN-1:0] hit;
    dec_t            res;
    dec_t            dec_d;
    dec_t            dec_q;

    csd_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .idx_i  (cfg_idx),
        .fld_i  (cfg_fld),
        .data_i (cfg_data),
        .win_o  (win)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        csd_window_match u_match (
            .win_i  (win[g]),
            .addr_i (addr),
            .wr_i   (is_write),
            .sup_i  (is_super),
            .hit_o  (hit[g])
        );
    end

    csd_resolve u_res (
        .cs_hit_i (hit[N_CS-1:0]),
        .dr_hit_i (hit[N_WIN-1:N_CS]),
        .win_i    (win),
        .dec_o    (res)
    );

    always_comb begin
        dec_d = dec_q;
        if (start) dec_d = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= DEC_IDLE;
        else        dec_q <= dec_d;
    end

    assign cs_sel     = dec_q.cs;
    assign dram_sel   = dec_q.dr;
    assign port_width = dec_q.pw;
    assign burst_inh  = dec_q.binh;
    assign int_ack_en = dec_q.iack;
    assign wait_cnt   = dec_q.wait_n;
    assign undef_err  = dec_q.undef;
    assign acc_kind   = dec_q.kind;
endmodule

// File: rtl/csd_checker.sv
module csd_checker
    import csd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [N_CS-1:0]   cs_sel,
    input logic [N_DR-1:0]   dram_sel,
    input logic [1:0]        port_width,
    input logic              burst_inh,
    input logic              int_ack_en,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic              undef_err,
    input logic [KIND_W-1:0] acc_kind
);
    a_r8_no_select_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> (cs_sel == '0 && dram_sel == '0 && acc_kind == K_UNDEF));

    a_r8_single_dram: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dram_sel) <= 1);

    a_r7_dram_excludes_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_sel != '0) |-> (cs_sel == '0 && acc_kind == K_DRAM && int_ack_en));

    a_r6_multi_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cs_sel) > 1) |-> (burst_inh && port_width == PW_32
                                      && !int_ack_en && acc_kind == K_MULTI));

    a_r4_external_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == K_EXT) |-> (cs_sel == '0 && dram_sel == '0 && burst_inh
                                 && port_width == PW_32 && wait_cnt == '0));

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable({cs_sel, dram_sel, port_width, burst_inh,
                            int_ack_en, wait_cnt, undef_err, acc_kind}));
endmodule

bind csd_resolver csd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cs_sel     (cs_sel),
    .dram_sel   (dram_sel),
    .port_width (port_width),
    .burst_inh  (burst_inh),
    .int_ack_en (int_ack_en),
    .wait_cnt   (wait_cnt),
    .undef_err  (undef_err),
    .acc_kind   (acc_kind)
);

// File: tb/tb_csd_resolver.sv
module tb_csd_resolver;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [1:0]  cfg_fld = '0;
    logic [31:0] cfg_data = '0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic        is_write = 1'b0;
    logic        is_super = 1'b0;
    logic [7:0]  cs_sel;
    logic [1:0]  dram_sel;
    logic [1:0]  port_width;
    logic        burst_inh;
    logic        int_ack_en;
    logic [3:0]  wait_cnt;
    logic        undef_err;
    logic [2:0]  acc_kind;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [21:0] exp_q[$];
    string       tag_q[$];

    csd_resolver dut (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [21:0] ex(logic [7:0] cs, logic [1:0] dr, logic [1:0] pw,
                                       logic bi, logic ia, logic [3:0] wt, logic un,
                                       logic [2:0] k);
        return {cs, dr, pw, bi, ia, wt, un, k};
    endfunction

    function automatic logic [31:0] ctl(logic v, logic rd, logic wr, logic sup, logic usr,
                                        logic [1:0] pw, logic ia, logic [3:0] wt, logic bu);
        logic [31:0] c = '0;
        c[0] = v; c[1] = rd; c[2] = wr; c[3] = sup; c[4] = usr;
        c[6:5] = pw; c[7] = ia; c[11:8] = wt; c[12] = bu;
        return c;
    endfunction

    function automatic logic [21:0] outs();
        return {cs_sel, dram_sel, port_width, burst_inh, int_ack_en, wait_cnt, undef_err, acc_kind};
    endfunction

    task automatic check(string tag, logic [21:0] act, logic [21:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] idx, logic [1:0] fld, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_fld = fld; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(string tag, logic [31:0] a, logic w, logic s, logic [21:0] e);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; is_write = w; is_super = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: result appears after the edge that samples start
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && start === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9: unexpected capture, actual %h expected none", outs());
                end else begin
                    check(tag_q.pop_front(), outs(), exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] held;
        logic [21:0] ext_e;
        logic [21:0] und_e;
        ext_e = ex(8'h00, 2'b00, 2'b00, 1, 0, 4'd0, 0, 3'd0);
        und_e = ex(8'h00, 2'b00, 2'b00, 1, 0, 4'd0, 1, 3'd4);
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), ext_e);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), ext_e);

        wr(4'd0, 2'd0, 32'h1000_0000); wr(4'd0, 2'd1, 32'h00FF_FFFF);
        wr(4'd0, 2'd2, ctl(1, 1, 1, 1, 1, 2'b01, 1, 4'd3, 1));
        wr(4'd1, 2'd0, 32'h2000_0000); wr(4'd1, 2'd1, 32'h0000_FFFF);
        wr(4'd1, 2'd2, ctl(1, 1, 0, 1, 0, 2'b10, 0, 4'd5, 0));
        wr(4'd2, 2'd0, 32'h3000_0000); wr(4'd2, 2'd1, 32'h00FF_FFFF);
        wr(4'd2, 2'd2, ctl(1, 1, 1, 1, 1, 2'b00, 1, 4'd1, 1));
        wr(4'd3, 2'd0, 32'h3000_0000); wr(4'd3, 2'd1, 32'h0000_FFFF);
        wr(4'd3, 2'd2, ctl(1, 1, 1, 1, 1, 2'b01, 1, 4'd7, 1));
        wr(4'd4, 2'd0, 32'h5000_0000); wr(4'd4, 2'd1, 32'h0FFF_FFFF);
        wr(4'd4, 2'd2, ctl(0, 1, 1, 1, 1, 2'b01, 1, 4'd2, 1));
        wr(4'd5, 2'd0, 32'h4100_0000); wr(4'd5, 2'd1, 32'h0000_FFFF);
        wr(4'd5, 2'd2, ctl(1, 1, 1, 1, 1, 2'b00, 0, 4'd0, 0));
        wr(4'd8, 2'd0, 32'h4000_0000); wr(4'd8, 2'd1, 32'h00FF_FFFF);
        wr(4'd8, 2'd2, ctl(1, 1, 1, 1, 1, 2'b00, 0, 4'd2, 1));
        wr(4'd9, 2'd0, 32'h4000_0000); wr(4'd9, 2'd1, 32'h0FFF_FFFF);
        wr(4'd9, 2'd2, ctl(1, 1, 1, 1, 1, 2'b00, 0, 4'd4, 0));

        access("R4 no window", 32'h1234_5678, 0, 0, ext_e);
        access("R5 R2 single cs0", 32'h10AB_CDEF, 1, 1,
               ex(8'h01, 2'b00, 2'b01, 0, 1, 4'd3, 0, 3'd1));
        access("R3 cs1 read supervisor", 32'h2000_1234, 0, 1,
               ex(8'h02, 2'b00, 2'b10, 1, 0, 4'd5, 0, 3'd1));
        access("R3 cs1 write denied", 32'h2000_1234, 1, 1, ext_e);
        access("R3 cs1 user denied", 32'h2000_1234, 0, 0, ext_e);
        access("R2 masked bit differs", 32'h2001_0000, 0, 1, ext_e);
        access("R6 cs2+cs3", 32'h3000_0010, 0, 0,
               ex(8'h0C, 2'b00, 2'b00, 1, 0, 4'd0, 0, 3'd2));
        access("R5 cs2 alone", 32'h3010_0000, 1, 0,
               ex(8'h04, 2'b00, 2'b00, 0, 1, 4'd1, 0, 3'd1));
        access("R2 disabled window", 32'h5000_0000, 0, 1, ext_e);
        access("R8 both dram", 32'h4010_0000, 0, 1, und_e);
        access("R7 dram1 only", 32'h4200_0000, 1, 0,
               ex(8'h00, 2'b10, 2'b00, 1, 1, 4'd4, 0, 3'd3));
        access("R8 dram+cs", 32'h4100_0004, 0, 0, und_e);

        wr(4'd0, 2'd3, 32'hFFFF_FFFF);
        wr(4'd12, 2'd2, 32'h0000_0000);
        access("R10 field 3 ignored", 32'h10AB_CDEF, 1, 1,
               ex(8'h01, 2'b00, 2'b01, 0, 1, 4'd3, 0, 3'd1));
        wr(4'd9, 2'd2, ctl(0, 1, 1, 1, 1, 2'b00, 0, 4'd4, 0));
        access("R7 R10 dram0 after disabling dram1", 32'h4010_0000, 0, 0,
               ex(8'h00, 2'b01, 2'b00, 0, 1, 4'd2, 0, 3'd3));
        wr(4'd0, 2'd2, ctl(1, 1, 1, 1, 1, 2'b11, 0, 4'd9, 0));
        access("R5 reserved width reads 32", 32'h1000_0040, 0, 0,
               ex(8'h01, 2'b00, 2'b00, 1, 0, 4'd9, 0, 3'd1));

        held = outs();
        wr(4'd0, 2'd2, 32'h0);
        addr = 32'h4200_0000;
        repeat (3) @(negedge clk);
        check("R9 hold across writes and idle", outs(), held);

        repeat (2) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule